// File: doc/BRIEF.md
# Inter-Processor Doorbell Signal Controller

This block lets processors on one chip ring numbered doorbells at each other. Software reaches it over a simple 32-bit register bus. Every command word is a packed identifier: the client number sits in bits 31:16 and the signal number in bits 15:0. Writing an identifier to the send offset puts that identifier on an outgoing strobe port for one cycle. The send completes at once and gives no completion indication.

For the local client, the block keeps a pending bit and an enable bit for each of `NUM_SIG` signals. A pending bit is set by a one-cycle incoming strobe that carries a signal number. Software handles doorbells in a loop:
1. Read the receive offset, which returns the identifier of the lowest-numbered signal that is both enabled and pending.
2. Write that identifier to the clear offset.
3. Repeat until the read returns all-ones.

A single active-high, level-sensitive interrupt stays asserted while any enabled signal is pending.

The offsets the block decodes are:

| Offset | Name | Access | Effect |
|--------|------|--------|--------|
| 0x0C | send | write | Emits the written identifier on `send_valid` / `send_id` for one cycle |
| 0x10 | receive | read | Returns the lowest enabled pending identifier, or 0xFFFFFFFF |
| 0x14 | enable | write | Unmasks the one named local signal |
| 0x18 | disable | write | Masks the one named local signal |
| 0x1C | clear | write | Drops the pending bit of the one named local signal |
| 0x38 | client clear | write | Drops every pending bit; the written data is ignored |

Top module: `doorbell_ctrl`

## Requirements
- R1: Every identifier uses bits 31:16 for the client number and bits 15:0 for the signal number. A non-empty receive read returns `CLIENT_ID` in bits 31:16 and the signal number in bits 15:0.
- R2: A write to offset 0x0C drives `send_valid` high for exactly the one cycle after the write edge, with `send_id` equal to the written word.
- R3: A read of offset 0x10 returns the lowest-numbered signal that is both pending and enabled. When no such signal exists, it returns 0xFFFFFFFF.
- R4: Writing a local identifier to offset 0x1C drops that signal's pending bit. The next receive read moves on to the next enabled pending signal, or to all-ones.
- R5: Writing an identifier to offset 0x14 sets the enable bit of that one signal, and writing it to offset 0x18 clears that one enable bit. No other signal changes.
- R6: `irq` is high exactly while at least one enabled signal is pending.
- R7: An enable, disable or clear write is ignored when the identifier's client field differs from `CLIENT_ID` or its signal field is `NUM_SIG` or above. Out-of-range signal numbers are never truncated onto a valid signal.
- R8: When an incoming strobe (`sig_in_valid` with `sig_in_num`) and a clear of the same signal arrive in the same cycle, the signal stays pending.
- R9: A write to offset 0x38 drops every pending bit and leaves every enable bit unchanged.
- R10: A masked signal still records its pending state. It appears at the receive offset and on `irq` as soon as it is enabled.
- R11: Reset clears all pending and enable bits and drives `send_valid` low. Right after reset, a receive read returns 0xFFFFFFFF and `irq` is low.
- R12: A read of any offset other than 0x10 returns zero. A write to an undecoded offset has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset, used for both writes and reads |
| bus_wdata | input | 32 | Write data, an identifier word |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| sig_in_valid | input | 1 | One-cycle strobe for an incoming doorbell |
| sig_in_num | input | SIG_W | Local signal number carried by the incoming strobe |
| send_valid | output | 1 | One-cycle strobe for an outgoing doorbell |
| send_id | output | 32 | Identifier of the outgoing doorbell |
| irq | output | 1 | Level summary interrupt |

## Verification
The directed sequence moves through specific states to show each behaviour on its own:
- **Masking:** a masked signal is pending alone; a lower masked signal is then enabled, which shows the lowest-first choice and that masked pending state is held.
- **Locality:** enable and disable are applied to one signal while others are pending, to show that only the named signal changes.
- **Decode filtering:** identifiers with a foreign client, or with a signal number that would alias onto a live signal if truncated, must leave the state as it was.
- **Set-versus-clear collision:** a strobe and a clear for the same signal arrive together, to show that the set wins.
- **Client clear:** a client clear runs with enables in place, to show that pending bits drop and enables survive.

A long random mix of all offsets, stray offsets and strobes is then compared cycle by cycle against a behavioural model. This exposes ordering and aliasing faults that the directed states do not reach.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

    localparam int unsigned ID_W = 32;

    localparam logic [7:0] OFF_SEND = 8'h0C;
    localparam logic [7:0] OFF_RECV = 8'h10;
    localparam logic [7:0] OFF_EN   = 8'h14;
    localparam logic [7:0] OFF_DIS  = 8'h18;
    localparam logic [7:0] OFF_CLR  = 8'h1C;
    localparam logic [7:0] OFF_CCLR = 8'h38;

    localparam logic [ID_W-1:0] NONE_ID = '1;

endpackage

// File: rtl/db_id_decode.sv
module db_id_decode #(
    parameter int unsigned NUM_SIG   = 16,
    parameter logic [15:0] CLIENT_ID = 16'h0005
) (
    input  logic [31:0]        id,
    output logic [NUM_SIG-1:0] sel
);

    logic client_hit;

    assign client_hit = (id[31:16] == CLIENT_ID);

    // Full 16-bit compare so that out-of-range signal numbers match nothing.
    for (genvar i = 0; i < NUM_SIG; i++) begin : g_sel
        assign sel[i] = client_hit && (id[15:0] == 16'(i));
    end

endmodule

// File: rtl/db_sig_bank.sv
module db_sig_bank #(
    parameter int unsigned NUM_SIG = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SIG-1:0] set_vec,
    input  logic [NUM_SIG-1:0] clr_vec,
    input  logic [NUM_SIG-1:0] en_vec,
    input  logic [NUM_SIG-1:0] dis_vec,
    input  logic               cclr,
    output logic [NUM_SIG-1:0] pend,
    output logic [NUM_SIG-1:0] en
);

    typedef struct packed {
        logic [NUM_SIG-1:0] pend;
        logic [NUM_SIG-1:0] en;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;

        bank_d.en = (bank_q.en | en_vec) & ~dis_vec;

        if (cclr) begin
            bank_d.pend = '0;
        end else begin
            bank_d.pend = bank_q.pend & ~clr_vec;
        end

        // Set takes priority over any clear in the same cycle.
        bank_d.pend = bank_d.pend | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign pend = bank_q.pend;
    assign en   = bank_q.en;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec))) else $error("set lost");   // R8

    AST_CCLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cclr && (set_vec == '0)) |=> (pend == '0)) else $error("client clear left pending");        // R9

    AST_CCLR_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (cclr && (en_vec == '0) && (dis_vec == '0)) |=> $stable(en)) else $error("enable lost");     // R9

    AST_EN_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_vec | dis_vec) != '0) |=>
            (((en ^ $past(en)) & ~($past(en_vec) | $past(dis_vec))) == '0)) else $error("enable leak"); // R5

endmodule

// File: rtl/db_pick_lowest.sv
module db_pick_lowest #(
    parameter int unsigned NUM_SIG = 16,
    localparam int unsigned SIG_W  = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1
) (
    input  logic [NUM_SIG-1:0] req,
    output logic               valid,
    output logic [SIG_W-1:0]   idx
);

    always_comb begin
        idx   = '0;
        valid = 1'b0;
        // Scan from the top down so that the lowest requester is the last write.
        for (int i = NUM_SIG - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = SIG_W'(i);
                valid = 1'b1;
            end
        end
    end

    always_comb begin
        if (valid) begin
            AST_PICK_IS_REQ: assert (req[idx]) else $error("picked idle signal");                   // R3
            AST_PICK_LOWEST: assert ((req & ((NUM_SIG'(1) << idx) - NUM_SIG'(1))) == '0)
                else $error("lower requester skipped");                                            // R3
        end
    end

endmodule

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl
    import doorbell_pkg::*;
#(
    parameter int unsigned NUM_SIG   = 16,
    parameter logic [15:0] CLIENT_ID = 16'h0005,
    parameter int unsigned ADDR_W    = 8,
    localparam int unsigned SIG_W    = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              sig_in_valid,
    input  logic [SIG_W-1:0]  sig_in_num,
    output logic              send_valid,
    output logic [31:0]       send_id,
    output logic              irq
);

    typedef struct packed {
        logic        valid;
        logic [31:0] id;
    } send_t;

    send_t send_d, send_q;

    logic               wr_send, wr_en, wr_dis, wr_clr, wr_cclr;
    logic [NUM_SIG-1:0] id_sel;
    logic [NUM_SIG-1:0] set_vec, clr_vec, en_vec, dis_vec;
    logic [NUM_SIG-1:0] pend, en;
    logic               pick_valid;
    logic [SIG_W-1:0]   pick_idx;
    logic [31:0]        recv_id;

    assign wr_send = bus_wr && (bus_addr == ADDR_W'(OFF_SEND));
    assign wr_en   = bus_wr && (bus_addr == ADDR_W'(OFF_EN));
    assign wr_dis  = bus_wr && (bus_addr == ADDR_W'(OFF_DIS));
    assign wr_clr  = bus_wr && (bus_addr == ADDR_W'(OFF_CLR));
    assign wr_cclr = bus_wr && (bus_addr == ADDR_W'(OFF_CCLR));

    db_id_decode #(.NUM_SIG(NUM_SIG), .CLIENT_ID(CLIENT_ID)) u_decode (
        .id  (bus_wdata),
        .sel (id_sel)
    );

    assign en_vec  = wr_en  ? id_sel : '0;
    assign dis_vec = wr_dis ? id_sel : '0;
    assign clr_vec = wr_clr ? id_sel : '0;

    for (genvar i = 0; i < NUM_SIG; i++) begin : g_set
        assign set_vec[i] = sig_in_valid && (sig_in_num == SIG_W'(i));
    end

    db_sig_bank #(.NUM_SIG(NUM_SIG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_vec  (en_vec),
        .dis_vec (dis_vec),
        .cclr    (wr_cclr),
        .pend    (pend),
        .en      (en)
    );

    db_pick_lowest #(.NUM_SIG(NUM_SIG)) u_pick (
        .req   (pend & en),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    assign recv_id   = pick_valid ? {CLIENT_ID, 16'(pick_idx)} : NONE_ID;
    assign bus_rdata = (bus_addr == ADDR_W'(OFF_RECV)) ? recv_id : '0;
    assign irq       = |(pend & en);

    always_comb begin
        send_d       = send_q;
        send_d.valid = wr_send;
        if (wr_send) begin
            send_d.id = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            send_q <= '0;
        end else begin
            send_q <= send_d;
        end
    end

    assign send_valid = send_q.valid;
    assign send_id    = send_q.id;

    AST_SEND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_send |=> (send_valid && (send_id == $past(bus_wdata)))) else $error("send missing");    // R2

    AST_SEND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_send |=> !send_valid) else $error("stray send");                                        // R2

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (recv_id != NONE_ID)) else $error("irq and receive disagree");                      // R6

    AST_RECV_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        (recv_id != NONE_ID) |-> (recv_id[31:16] == CLIENT_ID)) else $error("bad client field");   // R1

endmodule

// File: tb/doorbell_ctrl_tb.sv
module doorbell_ctrl_tb_top;

    localparam int unsigned NSIG = 16;
    localparam logic [15:0] LC   = 16'h0005;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h10;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sig_in_valid = 1'b0;
    logic [3:0]  sig_in_num = '0;
    logic        send_valid;
    logic [31:0] send_id;
    logic        irq;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    doorbell_ctrl #(.NUM_SIG(NSIG), .CLIENT_ID(LC), .ADDR_W(8)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .sig_in_valid (sig_in_valid),
        .sig_in_num   (sig_in_num),
        .send_valid   (send_valid),
        .send_id      (send_id),
        .irq          (irq)
    );

    // Behavioural reference model
    bit          m_pend [NSIG];
    bit          m_en   [NSIG];
    bit          m_sv;
    logic [31:0] m_sid;

    function automatic logic [31:0] model_recv();
        for (int i = 0; i < NSIG; i++) begin
            if (m_pend[i] && m_en[i]) return {LC, 16'(i)};
        end
        return 32'hFFFF_FFFF;
    endfunction

    function automatic bit model_irq();
        for (int i = 0; i < NSIG; i++) begin
            if (m_pend[i] && m_en[i]) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSIG; i++) begin
                m_pend[i] = 1'b0;
                m_en[i]   = 1'b0;
            end
            m_sv  = 1'b0;
            m_sid = '0;
        end else begin
            int s;
            bit ok;
            s  = int'(bus_wdata[15:0]);
            ok = (bus_wdata[31:16] == LC) && (s < NSIG);
            m_sv = bus_wr && (bus_addr == 8'h0C);
            if (m_sv) m_sid = bus_wdata;
            if (bus_wr && bus_addr == 8'h14 && ok) m_en[s] = 1'b1;
            if (bus_wr && bus_addr == 8'h18 && ok) m_en[s] = 1'b0;
            if (bus_wr && bus_addr == 8'h38) begin
                for (int i = 0; i < NSIG; i++) m_pend[i] = 1'b0;
            end
            if (bus_wr && bus_addr == 8'h1C && ok) m_pend[s] = 1'b0;
            if (sig_in_valid) m_pend[int'(sig_in_num)] = 1'b1;
        end
        #5;
        if (rst_n) begin
            chk("R3/R12 model rdata", bus_rdata, (bus_addr == 8'h10) ? model_recv() : 32'h0);
            chk("R6 model irq", {31'b0, irq}, {31'b0, model_irq()});
            chk("R2 model send_valid", {31'b0, send_valid}, {31'b0, m_sv});
            if (m_sv) chk("R2 model send_id", send_id, m_sid);
        end
    end

    function automatic logic [31:0] lid(input int s);
        return {LC, 16'(s)};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h10; bus_wdata = '0;
        #1;
    endtask

    task automatic ring(input int s);
        @(negedge clk);
        sig_in_valid = 1'b1; sig_in_num = 4'(s);
        @(negedge clk);
        sig_in_valid = 1'b0;
        #1;
    endtask

    task automatic ring_and_clear(input int s);
        @(negedge clk);
        sig_in_valid = 1'b1; sig_in_num = 4'(s);
        bus_wr = 1'b1; bus_addr = 8'h1C; bus_wdata = lid(s);
        @(negedge clk);
        sig_in_valid = 1'b0;
        bus_wr = 1'b0; bus_addr = 8'h10; bus_wdata = '0;
        #1;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R11 reset rdata", bus_rdata, 32'hFFFF_FFFF);
        chk("R11 reset irq", {31'b0, irq}, 32'h0);
        chk("R11 reset send_valid", {31'b0, send_valid}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        ring(3);
        chk("R10 masked pending hidden", bus_rdata, 32'hFFFF_FFFF);
        chk("R6 masked irq low", {31'b0, irq}, 32'h0);
        wr(8'h14, lid(3));
        chk("R10 appears on enable", bus_rdata, lid(3));
        chk("R1 id format", bus_rdata, 32'h0005_0003);
        chk("R6 irq high", {31'b0, irq}, 32'h1);

        wr(8'h14, lid(7));
        ring(7);
        chk("R3 lowest of 3,7", bus_rdata, lid(3));
        ring(1);
        chk("R10 masked 1 not shown", bus_rdata, lid(3));
        wr(8'h14, lid(1));
        chk("R3 lowest becomes 1", bus_rdata, lid(1));
        wr(8'h18, lid(1));
        chk("R5 disable only 1", bus_rdata, lid(3));

        wr(8'h1C, lid(3));
        chk("R4 clear moves on", bus_rdata, lid(7));
        ring(3);
        chk("R4 3 back", bus_rdata, lid(3));
        wr(8'h18, {LC, 16'd19});
        chk("R7 out-of-range disable ignored", bus_rdata, lid(3));
        wr(8'h1C, {16'h0006, 16'd3});
        chk("R7 foreign client clear ignored", bus_rdata, lid(3));
        wr(8'h14, {16'h0006, 16'd0});
        ring(0);
        chk("R7 foreign client enable ignored", bus_rdata, lid(3));

        ring_and_clear(3);
        chk("R8 set wins over clear", bus_rdata, lid(3));
        wr(8'h1C, lid(3));
        chk("R4 clear 3 again", bus_rdata, lid(7));

        wr(8'h0C, 32'h0009_0004);
        chk("R2 send_valid pulse", {31'b0, send_valid}, 32'h1);
        chk("R2 send_id", send_id, 32'h0009_0004);
        @(negedge clk); #1;
        chk("R2 send one cycle", {31'b0, send_valid}, 32'h0);

        wr(8'h20, lid(1));
        chk("R12 stray write no effect", bus_rdata, lid(7));
        bus_addr = 8'h14; #1;
        chk("R12 other offset reads zero", bus_rdata, 32'h0);
        bus_addr = 8'h10; #1;

        wr(8'h38, 32'h0);
        chk("R9 client clear empties", bus_rdata, 32'hFFFF_FFFF);
        chk("R9 irq drops", {31'b0, irq}, 32'h0);
        ring(7);
        chk("R9 enable kept", bus_rdata, lid(7));

        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R11 reset mid-run", bus_rdata, 32'hFFFF_FFFF);
        @(negedge clk);
        rst_n = 1'b1;
        ring(7);
        chk("R11 enables cleared", bus_rdata, 32'hFFFF_FFFF);

        for (int n = 0; n < 400; n++) begin
            logic [7:0] offs [8];
            int pick;
            offs = '{8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h38, 8'h24, 8'h14};
            @(negedge clk);
            pick = int'($urandom_range(0, 7));
            bus_wr = ($urandom_range(0, 3) != 0) && (pick != 1);
            bus_addr = bus_wr ? offs[pick] : 8'h10;
            if ((pick == 5) && ($urandom_range(0, 5) != 0)) bus_wr = 1'b0;
            bus_wdata = {($urandom_range(0, 7) == 0) ? 16'h0006 : LC,
                         16'($urandom_range(0, 19))};
            sig_in_valid = ($urandom_range(0, 2) == 0);
            sig_in_num = 4'($urandom_range(0, 15));
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h10; sig_in_valid = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule